// File: doc/BRIEF.md
# Interrupting GPIO Bank

A register-mapped bank of general-purpose pins, up to 32 wide, that samples external levels, drives output values and raises interrupts on pin activity. Software configures each pin's direction, interrupt enable, trigger mode and input masking through a small single-cycle register port. Reads are combinational, so there are no wait states.

Each pin keeps a current value. Output pins take their value from data writes. Input pins take it from the external level, unless their mask bit freezes them. The value appears on a per-pin line output. Two capability masks fixed at build time state which pins may act as inputs and which may act as outputs, and the direction and mask writes respect them.

Edge triggers compare the current value with its copy from the previous clock. Level triggers raise the status bit on every cycle the level holds. Status bits are sticky until software clears them by writing ones. A single interrupt line is the OR of all status bits.

Top module: `gpio_irq_bank`

## Requirements
- R1: The trigger mode of pin i is the code {t2,t1,t0}, taken from bit i of the trigger registers at offsets 6, 5 and 4. The codes are 000 falling edge, 001 rising edge, 010 low level and 011 high level. Any code with t2=1 triggers on both edges.
- R2: A status bit is set only when the pin's enable bit (offset 3) is 1 in the cycle its trigger condition holds.
- R3: The status register (offset 7) is write-one-to-clear: a written 1 clears that bit and a written 0 leaves it unchanged. A trigger that occurs in the same cycle as a clear wins, so the bit stays set.
- R4: irq_o is high while any status bit is set and falls only in the cycle after a status clear write.
- R5: A direction write (offset 2, 1 = output) stores (w | ~IN_CAP) & OUT_CAP.
- R6: A data write (offset 0) stores w & OUT_CAP in a readback register (offset 1). Only pins that are currently outputs take that value; other output pins hold theirs.
- R7: An input pin copies pin_i at each clock unless its mask bit (offset 8) is 1, in which case it holds. Mask writes store w & IN_CAP.
- R8: line_o shows the pin values, which are readable at offset 0. An input change applied before a clock appears after that clock.
- R9: A level trigger re-sets its status bit on every cycle the level holds. This includes the cycle after the pin's enable is written to 1, and the cycle of a clear.
- R10: An edge sets the status bit at the clock after the one that updated the pin value.
- R11: After reset, every register, the status and irq_o read zero. Offsets 9 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data for addr_i, combinational |
| pin_i | input | NPINS | External pin levels |
| line_o | output | NPINS | Per-pin value outputs |
| stat_o | output | NPINS | Per-pin status bits |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are the ones where one cycle carries two events. One is a status clear that lands in the same cycle as a fresh trigger on the same pin. Another is a level-triggered pin whose enable is turned on while the level already holds. Directed steps build these cases on purpose by holding a level pin active across enable and clear writes. A long random run mixes register writes at every offset with random pin levels, so that trigger codes, direction changes and masks collide with edges arriving in the same cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_VAL  = 4'd0,
    REG_DWR  = 4'd1,
    REG_DIR  = 4'd2,
    REG_IEN  = 4'd3,
    REG_TRG0 = 4'd4,
    REG_TRG1 = 4'd5,
    REG_TRG2 = 4'd6,
    REG_STAT = 4'd7,
    REG_IMSK = 4'd8
  } reg_sel_e;

  // code {t2,t1,t0}; t2 overrides to both-edge
  function automatic logic trig_hit(input logic [2:0] code, input logic cur, input logic prv);
    logic h;
    if (code[2]) h = cur ^ prv;
    else begin
      unique case (code[1:0])
        2'b00:   h = prv & ~cur;
        2'b01:   h = cur & ~prv;
        2'b10:   h = ~cur;
        default: h = cur;
      endcase
    end
    return h;
  endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int               NPINS   = 32,
  parameter logic [NPINS-1:0] IN_CAP  = '1,
  parameter logic [NPINS-1:0] OUT_CAP = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  ien_o,
  output logic [NPINS-1:0]  trg0_o,
  output logic [NPINS-1:0]  trg1_o,
  output logic [NPINS-1:0]  trg2_o,
  output logic [NPINS-1:0]  imsk_o,
  output logic [NPINS-1:0]  dwr_o
);
  logic [NPINS-1:0] dir_q, ien_q, trg0_q, trg1_q, trg2_q, imsk_q, dwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      ien_q  <= '0;
      trg0_q <= '0;
      trg1_q <= '0;
      trg2_q <= '0;
      imsk_q <= '0;
      dwr_q  <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        REG_VAL:  dwr_q  <= wdata_i & OUT_CAP;
        REG_DIR:  dir_q  <= (wdata_i | ~IN_CAP) & OUT_CAP;
        REG_IEN:  ien_q  <= wdata_i;
        REG_TRG0: trg0_q <= wdata_i;
        REG_TRG1: trg1_q <= wdata_i;
        REG_TRG2: trg2_q <= wdata_i;
        REG_IMSK: imsk_q <= wdata_i & IN_CAP;
        default: ;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign ien_o  = ien_q;
  assign trg0_o = trg0_q;
  assign trg1_o = trg1_q;
  assign trg2_o = trg2_q;
  assign imsk_o = imsk_q;
  assign dwr_o  = dwr_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_cap_chk
    if (!IN_CAP[i] && OUT_CAP[i]) begin : g_force_out
      AST_DIR_FORCED_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == REG_DIR) |=> dir_q[i]); // R5
    end
    if (!OUT_CAP[i]) begin : g_force_in
      AST_DIR_FORCED_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == REG_DIR) |=> !dir_q[i]); // R5
    end
  end
endmodule

// File: rtl/gpio_pin_state.sv
module gpio_pin_state #(
  parameter int               NPINS   = 32,
  parameter logic [NPINS-1:0] OUT_CAP = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_wr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] imsk_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] val_o,
  output logic [NPINS-1:0] prv_o
);
  logic [NPINS-1:0] val_q, prv_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic nxt;
    always_comb begin
      nxt = val_q[i];
      if (dir_i[i]) begin
        if (data_wr_i) nxt = wdata_i[i] & OUT_CAP[i];
      end else if (!imsk_i[i]) begin
        nxt = pin_i[i];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[i] <= 1'b0;
        prv_q[i] <= 1'b0;
      end else begin
        val_q[i] <= nxt;
        prv_q[i] <= val_q[i];
      end
    end

    AST_MASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!dir_i[i] && imsk_i[i]) |=> (val_q[i] == $past(val_q[i]))); // R7
    AST_INPUT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!dir_i[i] && !imsk_i[i]) |=> (val_q[i] == $past(pin_i[i]))); // R7
    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dir_i[i] && !data_wr_i) |=> (val_q[i] == $past(val_q[i]))); // R6
  end

  assign val_o = val_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_wr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0] val_i,
  input  logic [NPINS-1:0] prv_i,
  input  logic [NPINS-1:0] ien_i,
  input  logic [NPINS-1:0] trg0_i,
  input  logic [NPINS-1:0] trg1_i,
  input  logic [NPINS-1:0] trg2_i,
  output logic [NPINS-1:0] stat_o,
  output logic             irq_o
);
  logic [NPINS-1:0] stat_q, hit;

  for (genvar i = 0; i < NPINS; i++) begin : g_trig
    assign hit[i] = ien_i[i] & trig_hit({trg2_i[i], trg1_i[i], trg0_i[i]}, val_i[i], prv_i[i]);

    // new trigger wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= (stat_q[i] & ~(clr_wr_i & wdata_i[i])) | hit[i];
    end

    AST_SET_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_q[i]) |-> $past(ien_i[i])); // R2
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[i] && !(clr_wr_i && wdata_i[i])) |=> stat_q[i]); // R3
    AST_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr_i && wdata_i[i] && !ien_i[i]) |=> !stat_q[i]); // R3
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int               NPINS   = 32,
  parameter logic [NPINS-1:0] IN_CAP  = 32'hFFFF_FF0F,
  parameter logic [NPINS-1:0] OUT_CAP = 32'h7FFF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  line_o,
  output logic [NPINS-1:0]  stat_o,
  output logic              irq_o
);
  logic [NPINS-1:0] dir, ien, trg0, trg1, trg2, imsk, dwr, val, prv, stat;
  logic             data_wr, clr_wr;

  assign data_wr = wr_en_i && (addr_i == REG_VAL);
  assign clr_wr  = wr_en_i && (addr_i == REG_STAT);

  gpio_cfg_regs #(.NPINS(NPINS), .IN_CAP(IN_CAP), .OUT_CAP(OUT_CAP)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .dir_o(dir), .ien_o(ien), .trg0_o(trg0), .trg1_o(trg1), .trg2_o(trg2),
    .imsk_o(imsk), .dwr_o(dwr)
  );

  gpio_pin_state #(.NPINS(NPINS), .OUT_CAP(OUT_CAP)) u_pins (
    .clk_i, .rst_ni, .data_wr_i(data_wr), .wdata_i,
    .dir_i(dir), .imsk_i(imsk), .pin_i, .val_o(val), .prv_o(prv)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_irq (
    .clk_i, .rst_ni, .clr_wr_i(clr_wr), .wdata_i,
    .val_i(val), .prv_i(prv), .ien_i(ien),
    .trg0_i(trg0), .trg1_i(trg1), .trg2_i(trg2),
    .stat_o(stat), .irq_o
  );

  always_comb begin
    unique case (addr_i)
      REG_VAL:  rdata_o = val;
      REG_DWR:  rdata_o = dwr;
      REG_DIR:  rdata_o = dir;
      REG_IEN:  rdata_o = ien;
      REG_TRG0: rdata_o = trg0;
      REG_TRG1: rdata_o = trg1;
      REG_TRG2: rdata_o = trg2;
      REG_STAT: rdata_o = stat;
      REG_IMSK: rdata_o = imsk;
      default:  rdata_o = '0;
    endcase
  end

  assign line_o = val;
  assign stat_o = stat;

  AST_IRQ_FALL_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_wr)); // R4
  AST_LINE_FROM_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(dir[0]) && !$past(imsk[0])) |-> (line_o[0] == $past(pin_i[0]))); // R8
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam int          NP   = 32;
  localparam logic [31:0] INC  = 32'hFFFF_FF0F;
  localparam logic [31:0] OUTC = 32'h7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, pins = '0;
  logic [31:0] rdata, line, stat;
  logic        irq;

  int checks = 0, errors = 0;

  logic [31:0] m_val, m_prv, m_stat, m_dir, m_ien, m_t0, m_t1, m_t2, m_imsk, m_dwr;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NPINS(NP), .IN_CAP(INC), .OUT_CAP(OUTC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .line_o(line), .stat_o(stat), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic ref_hit(input logic [2:0] c, input logic cur, input logic prv);
    if (c[2]) return cur != prv;
    case (c[1:0])
      2'b00: return prv && !cur;
      2'b01: return cur && !prv;
      2'b10: return !cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] ref_read(input logic [3:0] a);
    case (a)
      4'd0: return m_val;
      4'd1: return m_dwr;
      4'd2: return m_dir;
      4'd3: return m_ien;
      4'd4: return m_t0;
      4'd5: return m_t1;
      4'd6: return m_t2;
      4'd7: return m_stat;
      4'd8: return m_imsk;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(input bit wr, input logic [3:0] a, input logic [31:0] d, input logic [31:0] p);
    logic [31:0] h, nv, clr;
    for (int i = 0; i < NP; i++) begin
      h[i] = ref_hit({m_t2[i], m_t1[i], m_t0[i]}, m_val[i], m_prv[i]);
      if (m_dir[i]) nv[i] = (wr && a == 4'd0) ? (d[i] & OUTC[i]) : m_val[i];
      else          nv[i] = m_imsk[i] ? m_val[i] : p[i];
    end
    clr = (wr && a == 4'd7) ? d : 32'h0;
    m_stat = (m_stat & ~clr) | (h & m_ien);
    m_prv = m_val;
    m_val = nv;
    if (wr) begin
      case (a)
        4'd0: m_dwr  = d & OUTC;
        4'd2: m_dir  = (d | ~INC) & OUTC;
        4'd3: m_ien  = d;
        4'd4: m_t0   = d;
        4'd5: m_t1   = d;
        4'd6: m_t2   = d;
        4'd8: m_imsk = d & INC;
        default: ;
      endcase
    end
  endtask

  // inputs applied at negedge, model follows the posedge, back at negedge
  task automatic cyc(input bit wr, input logic [3:0] a, input logic [31:0] d, input logic [31:0] p);
    wr_en = wr; addr = a; wdata = d; pins = p;
    @(posedge clk);
    model_step(wr, a, d, p);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a);
    addr = a;
    #1;
    check(req, rdata, ref_read(a));
  endtask

  task automatic cmp_outputs();
    check("R8 line", line, m_val);
    check("R1 stat", stat, m_stat);
    check("R4 irq", {31'b0, irq}, {31'b0, |m_stat});
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    {m_val, m_prv, m_stat, m_dir, m_ien, m_t0, m_t1, m_t2, m_imsk, m_dwr} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state and unmapped offsets
    for (int a = 0; a < 16; a++) rd("R11 reset read", 4'(a));
    check("R11 irq", {31'b0, irq}, 32'h0);

    // R5 direction forcing
    cyc(1, 4'd2, 32'h0, 32'h0);
    addr = 4'd2; #1; check("R5 dir zero", rdata, 32'h0000_00F0);
    cyc(1, 4'd2, 32'hFFFF_FFFF, 32'h0);
    addr = 4'd2; #1; check("R5 dir ones", rdata, 32'h7FFF_FFFF);

    // R6 data write to lower-half outputs
    cyc(1, 4'd2, 32'h0000_FFFF, 32'h0);
    cyc(1, 4'd0, 32'hAAAA_5555, 32'h0);
    addr = 4'd1; #1; check("R6 readback", rdata, 32'h2AAA_5555);
    addr = 4'd0; #1; check("R6 value", rdata, 32'h0000_5555);

    // R7 mask freezes inputs
    cyc(1, 4'd8, 32'h00FF_0000, 32'h0);
    cyc(0, 4'd0, 32'h0, 32'hFFFF_FFFF);
    cyc(0, 4'd0, 32'h0, 32'hFFFF_FFFF);
    addr = 4'd0; #1; check("R7 masked value", rdata, 32'hFF00_5555);
    check("R8 line", line, 32'hFF00_5555);
    cyc(1, 4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    addr = 4'd8; #1; check("R7 mask cap", rdata, INC);

    // R1 R2 R10: modes on pins 0..3 and 8
    cyc(1, 4'd8, 32'h0, 32'h0);
    cyc(1, 4'd2, 32'h0, 32'h0);
    cyc(1, 4'd4, 32'h0000_0009, 32'h0);
    cyc(1, 4'd5, 32'h0000_000C, 32'h0);
    cyc(1, 4'd6, 32'h0000_0100, 32'h0);
    cyc(0, 4'd0, 32'h0, 32'h0);
    cyc(1, 4'd3, 32'h0000_010B, 32'h0);
    cyc(1, 4'd7, 32'hFFFF_FFFF, 32'h0);
    check("R2 clear settle", stat, 32'h0);
    cyc(0, 4'd0, 32'h0, 32'h0000_010B);
    check("R10 no status yet", stat, 32'h0);
    cyc(0, 4'd0, 32'h0, 32'h0000_010B);
    check("R1 R10 edge and level", stat, 32'h0000_0109);
    cmp_outputs();

    // R9 enable while level holds
    cyc(1, 4'd3, 32'h0000_010F, 32'h0000_010B);
    cyc(0, 4'd0, 32'h0, 32'h0000_010B);
    check("R9 late enable", stat, 32'h0000_010D);

    // R3 clear one, set-wins on levels, zero write no effect
    cyc(1, 4'd7, 32'h0000_000D, 32'h0000_010B);
    check("R3 w1c and level re-set", stat, 32'h0000_010C);
    cyc(1, 4'd7, 32'h0, 32'h0000_010B);
    check("R3 zero write", stat, 32'h0000_010C);

    // R4 irq drop
    check("R4 irq high", {31'b0, irq}, 32'h1);
    cyc(1, 4'd3, 32'h0, 32'h0000_010B);
    cyc(1, 4'd7, 32'hFFFF_FFFF, 32'h0000_010B);
    check("R4 stat cleared", stat, 32'h0);
    check("R4 irq low", {31'b0, irq}, 32'h0);
    cmp_outputs();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  a;
      logic [31:0] d, p;
      bit          wr;
      rd("R11 random read", 4'($urandom_range(0, 15)));
      wr = ($urandom_range(0, 3) == 0);
      a  = 4'($urandom_range(0, 9));
      d  = $urandom();
      p  = ($urandom_range(0, 1) == 0) ? pins : (pins ^ $urandom());
      cyc(wr, a, d, p);
      cmp_outputs();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule